// File: doc/BRIEF.md
# Channel Inactivity Timer

This block watches a single DMA channel for idle time. Software programs a control word that holds the timer in reset or releases it, starts or stops counting, picks one-shot or periodic behaviour, and sets a 16-bit threshold. The timer counts clock cycles while it is released and running. When the count reaches a nonzero threshold, it raises the channel's timer event for one cycle.

Each pulse on the activity input means the channel did some work, and it restarts the count from zero. In one-shot mode the timer stops after its first expiry. It stays stopped until software clears the release bit and then sets it again. In periodic mode the count goes back to zero at expiry and keeps counting. Software can read the live count at any time through the same register port.

Top module: `chan_idle_timer`

## Requirements
- R1: The control register sits at address 0. Its release bit is bit 31, its run bit is bit 30 and its mode bit is bit 29 (0 = one-shot, 1 = periodic). The threshold is in bits 15..0. Every other bit reads as 0. A write takes effect at the clock edge where wr_en is sampled high. That same edge still counts with the previous settings.
- R2: After rst_n, the control register, the count and tmr_event are all 0. While the release bit is 0, each edge forces the count to 0 and re-arms one-shot mode.
- R3: Counting happens when release=1, run=1, the one-shot latch is clear, activity is low and no expiry occurs. On each such edge the count rises by exactly 1 and wraps modulo 2^16. With run=0 the count holds.
- R4: The count reads in bits 15..0 of address 1, and bits 31..16 read as 0. Writes to address 1 change neither the count nor the control register.
- R5: Expiry happens at an edge where the timer is running and the count equals a nonzero threshold. tmr_event is then 1 for exactly the next cycle.
- R6: In periodic mode the count becomes 0 at the expiry edge, and counting continues from there.
- R7: In one-shot mode the count holds at the threshold after expiry, and no further event occurs. This lasts until the release bit is written 0 and then 1.
- R8: When activity is high at an edge of a released timer, the count becomes 0. This takes priority over counting and over expiry, so no event is raised. Activity does not re-arm a one-shot timer that has already expired.
- R9: With a threshold of 0 the timer never expires. The count keeps wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select, used for both reads and writes: 0 = control, 1 = count |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, a combinational view of the selected register |
| activity | input | 1 | Channel activity pulse; clears the count |
| tmr_event | output | 1 | Timer expiry event, one cycle long |

## Verification
rd_data is a combinational mux of registered state. It is therefore due in the same cycle that addr is driven. A write, an activity pulse or an expiry all change the count and the control register at the very next edge. tmr_event is registered from the expiry condition, so it appears one edge after the count equals the threshold. In periodic mode, that is the same cycle in which the count reads 0. The bench drives inputs on the falling edge and lets them settle, then compares rd_data and tmr_event against its own model before the next rising edge. It advances the model only after that edge. As a result, every comparison lines up with exactly one register stage.

// File: rtl/chan_idle_timer.sv
module chan_idle_timer #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          activity,
  output logic          tmr_event
);
  localparam int REL_B  = DW - 1;
  localparam int RUN_B  = DW - 2;
  localparam int MODE_B = DW - 3;
  localparam logic [DW-1:0] CTRL_MASK = {3'b111, {(DW-3-CW){1'b0}}, {CW{1'b1}}};

  logic [DW-1:0] ctrl_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          evt_q;

  logic          rel, run, periodic, hit;
  logic [CW-1:0] thr;

  assign rel      = ctrl_q[REL_B];
  assign run      = ctrl_q[RUN_B];
  assign periodic = ctrl_q[MODE_B];
  assign thr      = ctrl_q[CW-1:0];
  assign hit      = run && !done_q && (thr != '0) && (cnt_q == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (wr_en && !addr) ctrl_q <= wr_data & CTRL_MASK;
      evt_q <= rel && !activity && hit;
      if (!rel) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (activity) begin
        cnt_q <= '0;
      end else if (hit) begin
        if (periodic) cnt_q <= '0;
        else          done_q <= 1'b1;
      end else if (run && !done_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rd_data   = addr ? {{(DW-CW){1'b0}}, cnt_q} : ctrl_q;
  assign tmr_event = evt_q;
endmodule

// File: rtl/chan_idle_timer_chk.sv
module chan_idle_timer_chk #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          activity,
  input logic [DW-1:0] ctrl_q,
  input logic [CW-1:0] cnt_q,
  input logic          done_q,
  input logic          evt_q
);
  localparam int REL_B  = DW - 1;
  localparam int RUN_B  = DW - 2;
  localparam int MODE_B = DW - 3;

  a_r2_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[REL_B] |=> (cnt_q == '0) && !evt_q);

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[REL_B] && ctrl_q[RUN_B] && !done_q && !activity &&
    ((ctrl_q[CW-1:0] == '0) || (cnt_q != ctrl_q[CW-1:0]))
    |=> cnt_q == CW'($past(cnt_q) + 1'b1));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);

  a_r6_periodic_restart: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q && $past(ctrl_q[MODE_B]) |-> cnt_q == '0);

  a_r7_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_q) && $past(ctrl_q[REL_B]) && !$past(activity) |-> $stable(cnt_q) && !evt_q);

  a_r8_activity_clear: assert property (@(posedge clk) disable iff (!rst_n)
    activity && ctrl_q[REL_B] |=> (cnt_q == '0) && !evt_q);

  a_r9_zero_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CW-1:0] == '0) |=> !evt_q);
endmodule

bind chan_idle_timer chan_idle_timer_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .activity(activity), .ctrl_q(ctrl_q),
  .cnt_q(cnt_q), .done_q(done_q), .evt_q(evt_q)
);

// File: tb/chan_idle_timer_test.sv
module chan_idle_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        activity = 1'b0;
  logic        tmr_event;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  logic [31:0] m_ctrl = '0;
  logic [15:0] m_cnt = '0;
  logic        m_done = 1'b0;
  logic        m_evt = 1'b0;

  always #10 clk = ~clk;

  chan_idle_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .activity(activity), .tmr_event(tmr_event)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic a);
    return a ? {16'h0, m_cnt} : m_ctrl;
  endfunction

  task automatic model_edge(input logic w, input logic a, input logic [31:0] d, input logic act);
    logic [15:0] thr;
    logic        expire;
    thr = m_ctrl[15:0];
    expire = m_ctrl[30] && !m_done && (thr != 0) && (m_cnt == thr);
    m_evt = m_ctrl[31] && !act && expire;
    if (!m_ctrl[31]) begin
      m_cnt = 0; m_done = 0;
    end else if (act) m_cnt = 0;
    else if (expire) begin
      if (m_ctrl[29]) m_cnt = 0; else m_done = 1;
    end else if (m_ctrl[30] && !m_done) m_cnt = m_cnt + 16'd1;
    if (w && !a) m_ctrl = d & 32'hE000_FFFF;
  endtask

  task automatic cyc(input logic w, input logic a, input logic [31:0] d, input logic act);
    wr_en = w; addr = a; wr_data = d; activity = act;
    #1;
    chk(a ? "R4 count readback" : "R1 control readback", rd_data, exp_read(a));
    chk("R5 event", {31'h0, tmr_event}, {31'h0, m_evt});
    @(posedge clk);
    model_edge(w, a, d, act);
    @(negedge clk);
    wr_en = 0; activity = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic peek(input string req, input logic a, input logic [31:0] exp_v, input logic exp_e);
    addr = a;
    #1;
    chk(req, rd_data, exp_v);
    chk(req, {31'h0, tmr_event}, {31'h0, exp_e});
  endtask

  initial begin
    #(20 * 150000);
    if (!ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    peek("R2 reset control", 1'b0, 32'h0, 1'b0);
    peek("R2 reset count", 1'b1, 32'h0, 1'b0);
    rst_n = 1;
    @(negedge clk);

    cyc(1, 0, 32'hFFFF_FFFF, 0);
    peek("R1 masked write", 1'b0, 32'hE000_FFFF, 1'b0);
    cyc(1, 0, 32'h0, 0);
    cyc(1, 0, 32'hE000_0003, 0);
    peek("R2 released count zero", 1'b1, 32'h0, 1'b0);
    idle(3);
    peek("R3 counted to threshold", 1'b1, 32'h3, 1'b0);
    idle(1);
    peek("R6 periodic restart with R5 event", 1'b1, 32'h0, 1'b1);
    idle(1);
    peek("R5 event one cycle", 1'b1, 32'h1, 1'b0);
    idle(3);
    peek("R6 second period", 1'b1, 32'h0, 1'b1);

    cyc(1, 1, 32'h0000_1234, 0);
    peek("R4 count write ignored", 1'b1, 32'h1, 1'b0);
    peek("R4 control unchanged", 1'b0, 32'hE000_0003, 1'b0);

    cyc(1, 0, 32'h0, 0);
    cyc(1, 0, 32'hC000_0002, 0);
    peek("R2 count cleared", 1'b1, 32'h0, 1'b0);
    idle(3);
    peek("R7 one-shot expiry", 1'b1, 32'h2, 1'b1);
    idle(5);
    peek("R7 one-shot hold", 1'b1, 32'h2, 1'b0);
    cyc(0, 1, 32'h0, 1);
    peek("R8 activity clears", 1'b1, 32'h0, 1'b0);
    idle(4);
    peek("R7 stays expired after activity", 1'b1, 32'h0, 1'b0);
    cyc(1, 0, 32'h4000_0002, 0);
    cyc(1, 0, 32'hC000_0002, 0);
    idle(3);
    peek("R7 re-armed by release toggle", 1'b1, 32'h2, 1'b1);

    cyc(1, 0, 32'h0, 0);
    cyc(1, 0, 32'hE000_0002, 0);
    idle(2);
    cyc(0, 1, 32'h0, 1);
    peek("R8 activity beats expiry", 1'b1, 32'h0, 1'b0);

    cyc(1, 0, 32'h8000_0005, 0);
    idle(4);
    peek("R3 run low holds", 1'b1, 32'h1, 1'b0);

    cyc(1, 0, 32'h0, 0);
    cyc(1, 0, 32'hC000_0000, 0);
    idle(65535);
    peek("R9 count at max", 1'b1, 32'hFFFF, 1'b0);
    idle(1);
    peek("R9 wrap without event", 1'b1, 32'h0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      logic w, a, act;
      d = $urandom;
      d[15:0] = 16'($urandom_range(0, 6));
      if ($urandom_range(0, 9) != 0) d[31] = 1'b1;
      w = ($urandom_range(0, 11) == 0);
      a = $urandom_range(0, 1) != 0;
      act = ($urandom_range(0, 14) == 0);
      cyc(w, a, d, act);
    end

    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule